// File: doc/BRIEF.md
# ADC Bring-Up Sequencer

This block walks a multichannel delta-sigma ADC through its one-time configuration after power-on. It does not touch the serial wires itself. It hands single operations (a command byte, a register read or a register write) to a neighbouring command/register engine over a request/acknowledge handshake, and it waits for each operation to be acknowledged before it issues the next. Every register change is a read followed by a write of the same register, with only the targeted bit fields altered, so that bits this block does not own keep whatever value the converter holds.

A single start pulse captures the channel enable mask, the per-channel gain and input-select codes, the output-rate code and the reference choice. The block first checks the gain and input-select codes of the enabled channels. An illegal code aborts the run before any operation is issued. Otherwise the converter is reset, taken out of its default streaming mode, and given its rate and reference settings. Each channel is then programmed, or powered down if it is not enabled. The run ends with an offset calibration: the calibration is requested, conversions are started, a long wait is timed, and conversions are stopped. Both waits use one shared down-counter whose lengths are parameters in system clock cycles.

Top module: `adc_bringup_seq`

## Requirements
- R1: After reset, and until a start pulse is seen, opReq, seqDone and seqError are all low.
- R2: A valid run issues exactly 25 operations (for 8 channels), in this order. First the command 0x06 (reset) and the command 0x11 (leave streaming). Next a read and then a write of register 0x01, and a read and then a write of register 0x03. Next a read and then a write of register 0x05+n for n = 0 up to NCH-1. Last the commands 0x1A (offset calibration), 0x08 (start) and 0x0A (stop). opKind encodes 0 = command byte on opWrData, 1 = register read, 2 = register write.
- R3: At least RST_WAIT_CYC clock cycles pass between the acknowledge of the reset command and the request of the leave-streaming command.
- R4: The write to register 0x01 places rateCode in bits [2:0] and keeps bits [7:3] of the value read.
- R5: The write to register 0x03 keeps bits 6 and 4:0 of the value read. With refInternal = 1 it sets bit 7 and writes ref4V into bit 5. With refInternal = 0 it clears bit 7 and keeps bit 5.
- R6: For an enabled channel, the write puts the gain code in bits [6:4] and the input-select code in bits [2:0], and keeps bits 7 and 3. Gain codes and input-select codes sit at bits [3n+2:3n] of gainCodes and muxCodes.
- R7: For a channel whose mask bit is 0, the write sets bit 7 and keeps bits [6:0]. That channel's gain and input-select codes are not checked and have no effect.
- R8: If any enabled channel has a gain code outside {1,2,4,5,6} or an input-select code outside {0,1,3,4}, seqError is high for exactly one cycle, no operation is requested, and seqDone stays low.
- R9: At least CAL_WAIT_CYC clock cycles pass between the acknowledge of the start command and the request of the stop command.
- R10: After the stop command is acknowledged, seqDone is high for exactly one cycle and seqError stays low.
- R11: A start pulse during a run is ignored. The run keeps the configuration captured at its own start and ends with a single seqDone pulse.
- R12: While opReq is high and opAck is low, opReq, opKind, opAddr and opWrData hold steady into the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| startPulse | input | 1 | One-cycle request to begin bring-up |
| chanEnMask | input | NCH | Enabled channels, bit n for channel n |
| gainCodes | input | 3*NCH | Gain code per channel, bits [3n+2:3n] |
| muxCodes | input | 3*NCH | Input-select code per channel, bits [3n+2:3n] |
| rateCode | input | 3 | Output-rate code for register 0x01 |
| refInternal | input | 1 | 1 = internal reference buffer on, 0 = external reference |
| ref4V | input | 1 | With internal reference: 1 = 4.0 V, 0 = 2.4 V |
| opReq | output | 1 | Operation request to the command/register engine |
| opKind | output | 2 | 0 command, 1 register read, 2 register write |
| opAddr | output | 5 | Register address for reads and writes |
| opWrData | output | 8 | Command byte or register write value |
| opAck | input | 1 | One-cycle completion of the current operation |
| opRdData | input | 8 | Read value, valid with opAck on a read |
| seqDone | output | 1 | One-cycle pulse when bring-up completes |
| seqError | output | 1 | One-cycle pulse when the captured configuration is illegal |

## Verification
The bench's engine model fills the register file with a distinct non-zero pattern on every reset command. A write that rebuilds a register from scratch, instead of from the value read, shows up as wrong bits in bit 3, bit 6, bit 5 or the high rate bits. The runs cover both reference choices, both 4.0 V and 2.4 V, a full enable mask and partial ones. A design that skipped power-down, powered down the wrong channels, or swapped the gain and select fields would write the wrong channel bytes. Illegal codes are placed on enabled channels, which must abort with no traffic, and on disabled channels, which must not abort. A design that validated too much or too little fails one of these. The bench measures the two waits against the parameters, and it fires a second start halfway through a run. A design that restarted, or that recaptured the new rate, would give a wrong operation count or a wrong rate byte.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

  localparam int ADDR_W = 5;

  typedef enum logic [1:0] {
    OP_CMD = 2'd0,
    OP_RD  = 2'd1,
    OP_WR  = 2'd2
  } opKindT;

  typedef enum logic [2:0] {
    STEP_RESET,
    STEP_HALTSTREAM,
    STEP_CFG_RATE,
    STEP_CFG_REF,
    STEP_CHAN,
    STEP_OFFCAL,
    STEP_GO,
    STEP_HALT
  } stepT;

  localparam logic [7:0] BYTE_RESET      = 8'h06;
  localparam logic [7:0] BYTE_HALTSTREAM = 8'h11;
  localparam logic [7:0] BYTE_OFFCAL     = 8'h1A;
  localparam logic [7:0] BYTE_GO         = 8'h08;
  localparam logic [7:0] BYTE_HALT       = 8'h0A;

  localparam logic [ADDR_W-1:0] ADDR_RATE  = 5'h01;
  localparam logic [ADDR_W-1:0] ADDR_REF   = 5'h03;
  localparam logic [ADDR_W-1:0] ADDR_CHAN0 = 5'h05;

  typedef struct packed {
    logic capture;
    logic latchRd;
    logic loadRstTmr;
    logic loadCalTmr;
    logic runTmr;
    logic chanClr;
    logic chanInc;
  } seqStrobeT;

endpackage

// File: rtl/adc_seq_dpath.sv
module adc_seq_dpath
  import adc_seq_pkg::*;
#(
  parameter int NCH          = 8,
  parameter int RST_WAIT_CYC = 1800,
  parameter int CAL_WAIT_CYC = 30_600_000
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  seqStrobeT             strb,
  input  stepT                  step,
  input  opKindT                kind,
  input  logic [NCH-1:0]        chanEnMask,
  input  logic [3*NCH-1:0]      gainCodes,
  input  logic [3*NCH-1:0]      muxCodes,
  input  logic [2:0]            rateCode,
  input  logic                  refInternal,
  input  logic                  ref4V,
  input  logic [7:0]            opRdData,
  output logic [ADDR_W-1:0]     opAddr,
  output logic [7:0]            opWrData,
  output logic                  cfgBad,
  output logic                  timerZero,
  output logic                  lastChan
);

  localparam int CH_W    = (NCH > 1) ? $clog2(NCH) : 1;
  localparam int TMR_MAX = (RST_WAIT_CYC > CAL_WAIT_CYC) ? RST_WAIT_CYC : CAL_WAIT_CYC;
  localparam int TMR_W   = $clog2(TMR_MAX + 1);

  logic [NCH-1:0]   maskQ;
  logic [3*NCH-1:0] gainQ;
  logic [3*NCH-1:0] muxQ;
  logic [2:0]       rateQ;
  logic             refIntQ;
  logic             ref4Q;
  logic [7:0]       rdByte;
  logic [CH_W-1:0]  chanIdx;
  logic [TMR_W-1:0] tmrCnt;
  logic [NCH-1:0]   badVec;

  // configuration snapshot taken at start
  always_ff @(posedge clk) begin
    if (!rstN) begin
      maskQ   <= '0;
      gainQ   <= '0;
      muxQ    <= '0;
      rateQ   <= '0;
      refIntQ <= 1'b0;
      ref4Q   <= 1'b0;
    end else if (strb.capture) begin
      maskQ   <= chanEnMask;
      gainQ   <= gainCodes;
      muxQ    <= muxCodes;
      rateQ   <= rateCode;
      refIntQ <= refInternal;
      ref4Q   <= ref4V;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)             rdByte <= '0;
    else if (strb.latchRd) rdByte <= opRdData;
  end

  always_ff @(posedge clk) begin
    if (!rstN)             chanIdx <= '0;
    else if (strb.chanClr) chanIdx <= '0;
    else if (strb.chanInc) chanIdx <= chanIdx + 1'b1;
  end

  // one down-counter shared by the reset wait and the calibration wait
  always_ff @(posedge clk) begin
    if (!rstN)                             tmrCnt <= '0;
    else if (strb.loadRstTmr)              tmrCnt <= TMR_W'(RST_WAIT_CYC);
    else if (strb.loadCalTmr)              tmrCnt <= TMR_W'(CAL_WAIT_CYC);
    else if (strb.runTmr && tmrCnt != '0)  tmrCnt <= tmrCnt - 1'b1;
  end

  assign timerZero = (tmrCnt == '0);
  assign lastChan  = (chanIdx == CH_W'(NCH - 1));

  // legality of codes, enabled channels only
  for (genvar g = 0; g < NCH; g++) begin : gCodeChk
    logic [2:0] gq;
    logic [2:0] mq;
    logic       gainOk;
    logic       muxOk;
    assign gq     = gainQ[3*g +: 3];
    assign mq     = muxQ[3*g +: 3];
    assign gainOk = (gq == 3'd1) || (gq == 3'd2) || (gq == 3'd4) ||
                    (gq == 3'd5) || (gq == 3'd6);
    assign muxOk  = (mq == 3'd0) || (mq == 3'd1) || (mq == 3'd3) || (mq == 3'd4);
    assign badVec[g] = maskQ[g] && !(gainOk && muxOk);
  end
  assign cfgBad = |badVec;

  // field merges over the byte that was read
  logic [2:0] curGain;
  logic [2:0] curMux;
  logic [7:0] rateByte;
  logic [7:0] refByte;
  logic [7:0] chanByte;

  assign curGain  = gainQ[int'(chanIdx)*3 +: 3];
  assign curMux   = muxQ[int'(chanIdx)*3 +: 3];
  assign rateByte = {rdByte[7:3], rateQ};
  assign refByte  = refIntQ ? {1'b1, rdByte[6], ref4Q, rdByte[4:0]}
                            : {1'b0, rdByte[6:0]};
  assign chanByte = maskQ[chanIdx] ? {rdByte[7], curGain, rdByte[3], curMux}
                                   : (rdByte | 8'h80);

  always_comb begin
    case (step)
      STEP_CFG_RATE: opAddr = ADDR_RATE;
      STEP_CFG_REF:  opAddr = ADDR_REF;
      STEP_CHAN:     opAddr = ADDR_CHAN0 + ADDR_W'(chanIdx);
      default:       opAddr = '0;
    endcase
  end

  always_comb begin
    opWrData = '0;
    if (kind == OP_CMD) begin
      case (step)
        STEP_RESET:      opWrData = BYTE_RESET;
        STEP_HALTSTREAM: opWrData = BYTE_HALTSTREAM;
        STEP_OFFCAL:     opWrData = BYTE_OFFCAL;
        STEP_GO:         opWrData = BYTE_GO;
        STEP_HALT:       opWrData = BYTE_HALT;
        default:         opWrData = '0;
      endcase
    end else if (kind == OP_WR) begin
      case (step)
        STEP_CFG_RATE: opWrData = rateByte;
        STEP_CFG_REF:  opWrData = refByte;
        STEP_CHAN:     opWrData = chanByte;
        default:       opWrData = '0;
      endcase
    end
  end

endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
  import adc_seq_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      startPulse,
  input  logic      opAck,
  input  logic      cfgBad,
  input  logic      timerZero,
  input  logic      lastChan,
  output seqStrobeT strb,
  output stepT      step,
  output opKindT    kind,
  output logic      opReq,
  output logic      seqDone,
  output logic      seqError
);

  typedef enum logic [4:0] {
    S_IDLE, S_CHECK, S_FAIL, S_RST, S_RSTWAIT, S_HALTSTR,
    S_RDRATE, S_WRRATE, S_RDREF, S_WRREF, S_RDCH, S_WRCH,
    S_OFFCAL, S_GO, S_CALWAIT, S_HALT, S_DONE
  } stateT;

  stateT state, nextState;

  always_ff @(posedge clk) begin
    if (!rstN) state <= S_IDLE;
    else       state <= nextState;
  end

  always_comb begin
    nextState = state;
    strb      = '0;
    step      = STEP_RESET;
    kind      = OP_CMD;
    opReq     = 1'b0;
    seqDone   = 1'b0;
    seqError  = 1'b0;
    case (state)
      S_IDLE: if (startPulse) begin
        strb.capture = 1'b1;
        nextState    = S_CHECK;
      end
      S_CHECK: nextState = cfgBad ? S_FAIL : S_RST;
      S_FAIL: begin
        seqError  = 1'b1;
        nextState = S_IDLE;
      end
      S_RST: begin
        opReq = 1'b1;
        if (opAck) begin
          strb.loadRstTmr = 1'b1;
          nextState       = S_RSTWAIT;
        end
      end
      S_RSTWAIT: begin
        strb.runTmr = 1'b1;
        if (timerZero) nextState = S_HALTSTR;
      end
      S_HALTSTR: begin
        opReq = 1'b1;
        step  = STEP_HALTSTREAM;
        if (opAck) nextState = S_RDRATE;
      end
      S_RDRATE: begin
        opReq = 1'b1; kind = OP_RD; step = STEP_CFG_RATE;
        if (opAck) begin
          strb.latchRd = 1'b1;
          nextState    = S_WRRATE;
        end
      end
      S_WRRATE: begin
        opReq = 1'b1; kind = OP_WR; step = STEP_CFG_RATE;
        if (opAck) nextState = S_RDREF;
      end
      S_RDREF: begin
        opReq = 1'b1; kind = OP_RD; step = STEP_CFG_REF;
        if (opAck) begin
          strb.latchRd = 1'b1;
          nextState    = S_WRREF;
        end
      end
      S_WRREF: begin
        opReq = 1'b1; kind = OP_WR; step = STEP_CFG_REF;
        if (opAck) begin
          strb.chanClr = 1'b1;
          nextState    = S_RDCH;
        end
      end
      S_RDCH: begin
        opReq = 1'b1; kind = OP_RD; step = STEP_CHAN;
        if (opAck) begin
          strb.latchRd = 1'b1;
          nextState    = S_WRCH;
        end
      end
      S_WRCH: begin
        opReq = 1'b1; kind = OP_WR; step = STEP_CHAN;
        if (opAck) begin
          if (lastChan) nextState = S_OFFCAL;
          else begin
            strb.chanInc = 1'b1;
            nextState    = S_RDCH;
          end
        end
      end
      S_OFFCAL: begin
        opReq = 1'b1; step = STEP_OFFCAL;
        if (opAck) nextState = S_GO;
      end
      S_GO: begin
        opReq = 1'b1; step = STEP_GO;
        if (opAck) begin
          strb.loadCalTmr = 1'b1;
          nextState       = S_CALWAIT;
        end
      end
      S_CALWAIT: begin
        strb.runTmr = 1'b1;
        if (timerZero) nextState = S_HALT;
      end
      S_HALT: begin
        opReq = 1'b1; step = STEP_HALT;
        if (opAck) nextState = S_DONE;
      end
      S_DONE: begin
        seqDone   = 1'b1;
        nextState = S_IDLE;
      end
      default: nextState = S_IDLE;
    endcase
  end

endmodule

// File: rtl/adc_bringup_seq.sv
module adc_bringup_seq
  import adc_seq_pkg::*;
#(
  parameter int NCH          = 8,
  parameter int RST_WAIT_CYC = 1800,
  parameter int CAL_WAIT_CYC = 30_600_000
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               startPulse,
  input  logic [NCH-1:0]     chanEnMask,
  input  logic [3*NCH-1:0]   gainCodes,
  input  logic [3*NCH-1:0]   muxCodes,
  input  logic [2:0]         rateCode,
  input  logic               refInternal,
  input  logic               ref4V,
  output logic               opReq,
  output logic [1:0]         opKind,
  output logic [ADDR_W-1:0]  opAddr,
  output logic [7:0]         opWrData,
  input  logic               opAck,
  input  logic [7:0]         opRdData,
  output logic               seqDone,
  output logic               seqError
);

  seqStrobeT strb;
  stepT      step;
  opKindT    kind;
  logic      cfgBad;
  logic      timerZero;
  logic      lastChan;

  adc_seq_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .startPulse (startPulse),
    .opAck      (opAck),
    .cfgBad     (cfgBad),
    .timerZero  (timerZero),
    .lastChan   (lastChan),
    .strb       (strb),
    .step       (step),
    .kind       (kind),
    .opReq      (opReq),
    .seqDone    (seqDone),
    .seqError   (seqError)
  );

  adc_seq_dpath #(
    .NCH          (NCH),
    .RST_WAIT_CYC (RST_WAIT_CYC),
    .CAL_WAIT_CYC (CAL_WAIT_CYC)
  ) u_dpath (
    .clk         (clk),
    .rstN        (rstN),
    .strb        (strb),
    .step        (step),
    .kind        (kind),
    .chanEnMask  (chanEnMask),
    .gainCodes   (gainCodes),
    .muxCodes    (muxCodes),
    .rateCode    (rateCode),
    .refInternal (refInternal),
    .ref4V       (ref4V),
    .opRdData    (opRdData),
    .opAddr      (opAddr),
    .opWrData    (opWrData),
    .cfgBad      (cfgBad),
    .timerZero   (timerZero),
    .lastChan    (lastChan)
  );

  assign opKind = kind;

endmodule

// File: rtl/adc_bringup_seq_chk.sv
module adc_bringup_seq_chk
  import adc_seq_pkg::*;
#(
  parameter int RST_WAIT_CYC = 1800,
  parameter int CAL_WAIT_CYC = 30_600_000
) (
  input logic              clk,
  input logic              rstN,
  input logic              opReq,
  input logic [1:0]        opKind,
  input logic [ADDR_W-1:0] opAddr,
  input logic [7:0]        opWrData,
  input logic              opAck,
  input logic              seqDone,
  input logic              seqError
);

  localparam int LIM_MAX = (RST_WAIT_CYC > CAL_WAIT_CYC) ? RST_WAIT_CYC : CAL_WAIT_CYC;
  localparam int GW      = $clog2(LIM_MAX + 2);

  logic [GW-1:0] rstGap;
  logic [GW-1:0] calGap;
  logic          isCmd;

  assign isCmd = (opKind == 2'(OP_CMD));

  // cycles since the reset command and the start command were acknowledged
  always_ff @(posedge clk) begin
    if (!rstN) begin
      rstGap <= '0;
      calGap <= '0;
    end else begin
      if (opAck && isCmd && opWrData == BYTE_RESET) rstGap <= '0;
      else if (rstGap < GW'(RST_WAIT_CYC))          rstGap <= rstGap + 1'b1;
      if (opAck && isCmd && opWrData == BYTE_GO)    calGap <= '0;
      else if (calGap < GW'(CAL_WAIT_CYC))          calGap <= calGap + 1'b1;
    end
  end

  a_r3_reset_wait: assert property (@(posedge clk) disable iff (!rstN)
    (opReq && isCmd && opWrData == BYTE_HALTSTREAM) |-> (rstGap >= GW'(RST_WAIT_CYC)));

  a_r9_cal_wait: assert property (@(posedge clk) disable iff (!rstN)
    (opReq && isCmd && opWrData == BYTE_HALT) |-> (calGap >= GW'(CAL_WAIT_CYC)));

  a_r12_req_hold: assert property (@(posedge clk) disable iff (!rstN)
    (opReq && !opAck) |=> (opReq && $stable(opKind) && $stable(opAddr) && $stable(opWrData)));

  a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rstN)
    seqDone |=> !seqDone);

  a_r8_error_quiet: assert property (@(posedge clk) disable iff (!rstN)
    seqError |-> (!opReq && !seqDone));

  a_r8_error_pulse: assert property (@(posedge clk) disable iff (!rstN)
    seqError |=> !seqError);

endmodule

bind adc_bringup_seq adc_bringup_seq_chk #(
  .RST_WAIT_CYC (RST_WAIT_CYC),
  .CAL_WAIT_CYC (CAL_WAIT_CYC)
) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .opReq    (opReq),
  .opKind   (opKind),
  .opAddr   (opAddr),
  .opWrData (opWrData),
  .opAck    (opAck),
  .seqDone  (seqDone),
  .seqError (seqError)
);

// File: tb/adc_bringup_seq_bench.sv
module adc_bringup_seq_bench;

  localparam int NCH  = 8;
  localparam int RSTW = 20;
  localparam int CALW = 100;
  localparam int LAT  = 2;

  logic             clk = 1'b0;
  logic             rstN;
  logic             startPulse;
  logic [NCH-1:0]   chanEnMask;
  logic [3*NCH-1:0] gainCodes;
  logic [3*NCH-1:0] muxCodes;
  logic [2:0]       rateCode;
  logic             refInternal;
  logic             ref4V;
  logic             opReq;
  logic [1:0]       opKind;
  logic [4:0]       opAddr;
  logic [7:0]       opWrData;
  logic             opAck;
  logic [7:0]       opRdData;
  logic             seqDone;
  logic             seqError;

  always #2.5 clk = ~clk;

  adc_bringup_seq #(.NCH(NCH), .RST_WAIT_CYC(RSTW), .CAL_WAIT_CYC(CALW)) u_adc_bringup_seq (
    .clk(clk), .rstN(rstN), .startPulse(startPulse), .chanEnMask(chanEnMask),
    .gainCodes(gainCodes), .muxCodes(muxCodes), .rateCode(rateCode),
    .refInternal(refInternal), .ref4V(ref4V), .opReq(opReq), .opKind(opKind),
    .opAddr(opAddr), .opWrData(opWrData), .opAck(opAck), .opRdData(opRdData),
    .seqDone(seqDone), .seqError(seqError)
  );

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int checks = 0;
  int errors = 0;

  logic [7:0] regs [32];
  int logN = 0;
  int lKind [64];
  int lAddr [64];
  int lData [64];
  int lReq  [64];
  int lAck  [64];
  int doneHi = 0;
  int errHi  = 0;

  int cfgMask;
  int cfgGain [NCH];
  int cfgMux  [NCH];
  int cfgRate;
  int cfgRefInt;
  int cfg4V;

  function automatic logic [7:0] initVal(int a);
    return 8'((a * 37 + 90) & 255);
  endfunction

  always @(negedge clk) begin
    if (seqDone)  doneHi++;
    if (seqError) errHi++;
  end

  // command/register engine model
  initial begin
    opAck    = 1'b0;
    opRdData = '0;
    for (int i = 0; i < 32; i++) regs[i] = initVal(i);
    forever begin
      @(negedge clk);
      if (opReq === 1'b1) begin
        int rq;
        rq = cyc;
        repeat (LAT) @(negedge clk);
        if (opKind == 2'd0 && opWrData == 8'h06)
          for (int i = 0; i < 32; i++) regs[i] = initVal(i);
        else if (opKind == 2'd1) opRdData = regs[opAddr];
        else if (opKind == 2'd2) regs[opAddr] = opWrData;
        if (logN < 64) begin
          lKind[logN] = int'(opKind);
          lAddr[logN] = int'(opAddr);
          lData[logN] = int'(opWrData);
          lReq[logN]  = rq;
          lAck[logN]  = cyc;
        end
        logN++;
        opAck = 1'b1;
        @(negedge clk);
        opAck = 1'b0;
      end
    end
  end

  task automatic finishUp();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
    finishUp();
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic applyCfg();
    chanEnMask  = NCH'(cfgMask);
    for (int c = 0; c < NCH; c++) begin
      gainCodes[3*c +: 3] = 3'(cfgGain[c]);
      muxCodes[3*c +: 3]  = 3'(cfgMux[c]);
    end
    rateCode    = 3'(cfgRate);
    refInternal = cfgRefInt[0];
    ref4V       = cfg4V[0];
  endtask

  task automatic pulseStart();
    @(negedge clk) startPulse = 1'b1;
    @(negedge clk) startPulse = 1'b0;
  endtask

  task automatic beginRun();
    logN   = 0;
    doneHi = 0;
    errHi  = 0;
    applyCfg();
    pulseStart();
  endtask

  task automatic waitEnd();
    for (int i = 0; i < 4000; i++) begin
      @(negedge clk);
      if (seqDone || seqError) break;
    end
    repeat (5) @(negedge clk);
  endtask

  task automatic expOp(inout int idx, input int kind, input int addr, input int data,
                       input string tag);
    if (idx < logN) begin
      bit ok;
      ok = (lKind[idx] == kind) &&
           (kind == 0 || lAddr[idx] == addr) &&
           (kind == 1 || lData[idx] == data);
      chk(ok, tag, (lKind[idx] << 16) | (lAddr[idx] << 8) | lData[idx],
          (kind << 16) | (addr << 8) | data);
    end else begin
      chk(1'b0, tag, -1, (kind << 16) | (addr << 8) | data);
    end
    idx++;
  endtask

  task automatic verifyRun();
    int i = 0;
    int iv;
    chk(logN == 3 * 3 + 2 * NCH, "R2 operation count", logN, 3 * 3 + 2 * NCH);
    expOp(i, 0, 0, 'h06, "R2 reset command");
    expOp(i, 0, 0, 'h11, "R2 leave streaming command");
    expOp(i, 1, 1, 0, "R2 rate register read");
    expOp(i, 2, 1, (int'(initVal(1)) & 'hF8) | cfgRate, "R4 rate register write");
    expOp(i, 1, 3, 0, "R2 reference register read");
    iv = int'(initVal(3));
    if (cfgRefInt != 0) expOp(i, 2, 3, (iv & 'h5F) | 'h80 | (cfg4V << 5), "R5 internal reference write");
    else                expOp(i, 2, 3, iv & 'h7F, "R5 external reference write");
    for (int c = 0; c < NCH; c++) begin
      iv = int'(initVal(5 + c));
      expOp(i, 1, 5 + c, 0, "R2 channel read");
      if (((cfgMask >> c) & 1) != 0)
        expOp(i, 2, 5 + c, (iv & 'h88) | (cfgGain[c] << 4) | cfgMux[c], "R6 enabled channel write");
      else
        expOp(i, 2, 5 + c, iv | 'h80, "R7 disabled channel power-down");
    end
    expOp(i, 0, 0, 'h1A, "R2 offset calibration command");
    expOp(i, 0, 0, 'h08, "R2 start command");
    expOp(i, 0, 0, 'h0A, "R2 stop command");
    if (logN >= 2 * NCH + 9) begin
      chk(lReq[1] - lAck[0] >= RSTW, "R3 reset wait", lReq[1] - lAck[0], RSTW);
      chk(lReq[2*NCH+8] - lAck[2*NCH+7] >= CALW, "R9 calibration wait",
          lReq[2*NCH+8] - lAck[2*NCH+7], CALW);
    end
    chk(doneHi == 1, "R10 done pulse width", doneHi, 1);
    chk(errHi == 0, "R10 no error on success", errHi, 0);
  endtask

  task automatic setLegal();
    for (int c = 0; c < NCH; c++) begin
      cfgGain[c] = (c % 5 == 0) ? 1 : (c % 5 == 1) ? 2 : (c % 5 == 2) ? 4 : (c % 5 == 3) ? 5 : 6;
      cfgMux[c]  = (c % 4 == 0) ? 0 : (c % 4 == 1) ? 1 : (c % 4 == 2) ? 3 : 4;
    end
  endtask

  task automatic testReset();
    chk(opReq == 1'b0, "R1 no request after reset", int'(opReq), 0);
    chk(seqDone == 1'b0, "R1 done low after reset", int'(seqDone), 0);
    chk(seqError == 1'b0, "R1 error low after reset", int'(seqError), 0);
    repeat (10) @(negedge clk);
    chk(logN == 0, "R1 no operation without start", logN, 0);
  endtask

  task automatic testInternal4V();
    setLegal();
    cfgMask = 'hA7; cfgRate = 5; cfgRefInt = 1; cfg4V = 1;
    beginRun();
    waitEnd();
    verifyRun();
  endtask

  task automatic testExternalFull();
    for (int c = 0; c < NCH; c++) begin
      cfgGain[c] = 6 - (c % 2);
      cfgMux[c]  = 3 + (c % 2);
    end
    cfgMask = 'hFF; cfgRate = 2; cfgRefInt = 0; cfg4V = 1;
    beginRun();
    waitEnd();
    verifyRun();
  endtask

  task automatic testDisabledJunk();
    setLegal();
    for (int c = 4; c < NCH; c++) begin
      cfgGain[c] = 7;
      cfgMux[c]  = 7;
    end
    cfgMask = 'h0F; cfgRate = 0; cfgRefInt = 1; cfg4V = 0;
    beginRun();
    waitEnd();
    verifyRun();
  endtask

  task automatic testBadCode(input int chan, input int badGain, input int badMux);
    setLegal();
    if (badGain >= 0) cfgGain[chan] = badGain;
    if (badMux >= 0)  cfgMux[chan]  = badMux;
    cfgMask = 'hFF; cfgRate = 3; cfgRefInt = 1; cfg4V = 0;
    beginRun();
    waitEnd();
    repeat (20) @(negedge clk);
    chk(errHi == 1, "R8 error pulse width", errHi, 1);
    chk(doneHi == 0, "R8 no done on illegal code", doneHi, 0);
    chk(logN == 0, "R8 no operation on illegal code", logN, 0);
  endtask

  task automatic testBusyStart();
    setLegal();
    cfgMask = 'h5C; cfgRate = 1; cfgRefInt = 0; cfg4V = 0;
    beginRun();
    while (logN < 3) @(negedge clk);
    rateCode   = 3'd6;
    chanEnMask = '0;
    pulseStart();
    waitEnd();
    repeat (CALW + 200) @(negedge clk);
    chk(doneHi == 1, "R11 single done despite second start", doneHi, 1);
    verifyRun();
  endtask

  initial begin
    rstN        = 1'b0;
    startPulse  = 1'b0;
    chanEnMask  = '0;
    gainCodes   = '0;
    muxCodes    = '0;
    rateCode    = '0;
    refInternal = 1'b0;
    ref4V       = 1'b0;
    repeat (4) @(negedge clk);
    chk(opReq == 1'b0, "R1 no request during reset", int'(opReq), 0);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testInternal4V();
    testExternalFull();
    testDisabledJunk();
    testBadCode(3, 3, -1);
    testBadCode(6, -1, 2);
    testBusyStart();
    finishUp();
  end

endmodule